// File: doc/BRIEF.md
# Partitioned Masked CAM Array

This block is a small content-addressable memory. Each stored word sits beside two state bits. Empty marks an unused slot. Skip keeps a filled slot out of searches. A 3-bit partition code, which can change at run time, splits every word on segment boundaries into a searched CAM field and an associated RAM field. The RAM field can sit in either the low or the high part of the word.

A compare strobe checks a comparand against every filled, non-skipped entry. The check uses only the CAM field and drops the bits set in a compare mask. One cycle after the strobe, the block presents a registered match flag and the lowest-numbered matching entry.

An access port reads, writes, marks or frees one entry, with the write masked bit by bit. The entry address comes from one of four sources: an explicit address, an internal address register that steps up or down after each access, the next free entry, or the last match. A full flag and a next-free address are always available.

Top module: `pcam_top`

## Requirements
- R1: After a synchronous reset, every entry is Empty with Skip clear, and `addr_reg` is 0. `match_flag` is 0, `full_flag` is 0 and `next_free` is 0.
- R2: `part_code` selects the searched field, with SEG_W-bit segments numbered from the LSB. Codes 000 and 100 search the whole word. Codes 001, 010 and 011 leave the lowest 1, 2 or 3 segments unsearched. Codes 101, 110 and 111 leave the highest 1, 2 or 3 segments unsearched. Unsearched bits never affect a compare.
- R3: A `cmp_mask` bit of 1 drops that bit from the compare. A bit of 0 keeps it.
- R4: Only entries with Empty = 0 and Skip = 0 can match.
- R5: On the edge where `cmp_strobe` is 1, `match_flag` and `match_addr` are loaded. `match_flag` is the OR of all hits and `match_addr` is the lowest-numbered hit. Both hold their values while `cmp_strobe` is 0.
- R6: A write stores `(old & acc_mask) | (acc_data & ~acc_mask)`, so a mask bit of 1 keeps the stored bit. The write also clears the entry's Empty and Skip bits.
- R7: `full_flag` is 1 exactly when no entry is Empty. `next_free` is the lowest-numbered Empty entry, or 0 when the array is full.
- R8: `acc_src` selects the target address: 00 = `acc_addr`, 01 = `addr_reg`, 10 = `next_free`, 11 = `match_addr`. The access is dropped when the source is 10 and the array is full, when the source is 11 and `match_flag` is 0, or when the source is 00 and `acc_addr` is at or above ENTRIES.
- R9: `acc_op` 5 loads `addr_reg` from `acc_addr`. After a read or write that is not dropped, `addr_reg` changes according to `ar_step`: 01 increments it, 10 decrements it, and 00 or 11 leaves it unchanged. It wraps between 0 and ENTRIES-1.
- R10: `acc_op` encodes the operations as 0 = none, 1 = read, 2 = write, 3 = set Skip, 4 = free (Empty = 1, Skip = 0). A read loads the target word into `rd_data` one cycle later, and `rd_data` holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| part_code | input | 3 | CAM/RAM split code |
| cmp_strobe | input | 1 | Start a compare this cycle |
| comparand | input | WIDTH | Search key |
| cmp_mask | input | WIDTH | Compare mask, 1 = ignore bit |
| acc_op | input | 3 | Access operation |
| acc_src | input | 2 | Access address source |
| acc_addr | input | AW | Explicit address or address register load value |
| acc_data | input | WIDTH | Write data |
| acc_mask | input | WIDTH | Write mask, 1 = keep bit |
| ar_step | input | 2 | Address register step after an access |
| match_flag | output | 1 | Registered any-hit flag |
| match_addr | output | AW | Registered lowest hit index |
| full_flag | output | 1 | No Empty entry remains |
| next_free | output | AW | Lowest Empty entry |
| addr_reg | output | AW | Address register |
| rd_data | output | WIDTH | Registered read data |

## Verification
The bench builds the block with ENTRIES = 6, WIDTH = 64 and SEG_W = 16. Six entries can be filled in a few writes, so the full state and the dropped next-free write are reached quickly. Because six is not a power of two, the address register's wrap cannot come from a plain binary rollover and must come from the explicit ENTRIES-1 bound. The 64-bit word holds four segments, so the bench drives every one of the eight partition codes, including the code that aliases the all-CAM split.

// File: rtl/pcam_pkg.sv
package pcam_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_READ    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_SKIP    = 3'd3,
        OP_FREE    = 3'd4,
        OP_LOAD_AR = 3'd5
    } pcam_op_e;

    typedef enum logic [1:0] {
        SRC_DIRECT = 2'd0,
        SRC_AREG   = 2'd1,
        SRC_FREE   = 2'd2,
        SRC_MATCH  = 2'd3
    } pcam_src_e;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_INC   = 2'd1,
        STEP_DEC   = 2'd2,
        STEP_HOLD3 = 2'd3
    } pcam_step_e;

    typedef struct packed {
        logic empty;
        logic skip;
    } pcam_flags_t;

    localparam pcam_flags_t FLAGS_FREE = '{empty: 1'b1, skip: 1'b0};
    localparam pcam_flags_t FLAGS_USED = '{empty: 1'b0, skip: 1'b0};

endpackage

// File: rtl/pcam_part_decode.sv
module pcam_part_decode #(
    parameter int WIDTH = 64,
    parameter int SEG_W = 16
) (
    input  logic [2:0]       part_code,
    output logic [WIDTH-1:0] cam_keep
);
    localparam int NSEG = WIDTH / SEG_W;

    logic [1:0] n_ram;
    logic       ram_hi;

    assign n_ram  = part_code[1:0];
    assign ram_hi = part_code[2];

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic in_ram;
        assign in_ram = ram_hi ? (s >= NSEG - int'(n_ram)) : (s < int'(n_ram));
        assign cam_keep[s*SEG_W +: SEG_W] = {SEG_W{~in_ram}};
    end

endmodule

// File: rtl/pcam_prio.sv
module pcam_prio #(
    parameter int N = 16,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [AW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
    end
endmodule

// File: rtl/pcam_array.sv
module pcam_array
    import pcam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 64,
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic               set_skip,
    input  logic               set_free,
    input  logic [AW-1:0]      idx,
    input  logic [WIDTH-1:0]   wdata,
    input  logic [WIDTH-1:0]   wmask,
    input  logic [WIDTH-1:0]   comparand,
    input  logic [WIDTH-1:0]   cmp_mask,
    input  logic [WIDTH-1:0]   cam_keep,
    output logic [ENTRIES-1:0] hits,
    output logic [ENTRIES-1:0] empties,
    output logic [WIDTH-1:0]   rd_word
);
    logic [WIDTH-1:0] mem_q   [ENTRIES];
    pcam_flags_t      flags_q [ENTRIES];

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (rst) begin
                mem_q[e]   <= '0;
                flags_q[e] <= FLAGS_FREE;
            end else if (idx == AW'(e)) begin
                if (we) begin
                    mem_q[e]   <= (mem_q[e] & wmask) | (wdata & ~wmask);
                    flags_q[e] <= FLAGS_USED;
                end else if (set_skip) begin
                    flags_q[e].skip <= 1'b1;
                end else if (set_free) begin
                    flags_q[e] <= FLAGS_FREE;
                end
            end
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hits[e] = !flags_q[e].empty && !flags_q[e].skip &&
                         (((mem_q[e] ^ comparand) & ~cmp_mask & cam_keep) == '0);
        assign empties[e] = flags_q[e].empty;
    end

    assign rd_word = mem_q[idx];

    // R6
    masked_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (((mem_q[$past(idx)] ^ $past(wdata)) & ~$past(wmask)) == '0));

    // R6
    write_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (!flags_q[$past(idx)].empty && !flags_q[$past(idx)].skip));

endmodule

// File: rtl/pcam_top.sv
module pcam_top
    import pcam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 64,
    parameter int SEG_W   = 16,
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       part_code,
    input  logic             cmp_strobe,
    input  logic [WIDTH-1:0] comparand,
    input  logic [WIDTH-1:0] cmp_mask,
    input  logic [2:0]       acc_op,
    input  logic [1:0]       acc_src,
    input  logic [AW-1:0]    acc_addr,
    input  logic [WIDTH-1:0] acc_data,
    input  logic [WIDTH-1:0] acc_mask,
    input  logic [1:0]       ar_step,
    output logic             match_flag,
    output logic [AW-1:0]    match_addr,
    output logic             full_flag,
    output logic [AW-1:0]    next_free,
    output logic [AW-1:0]    addr_reg,
    output logic [WIDTH-1:0] rd_data
);
    localparam logic [AW:0]   TOP_IDX  = (AW+1)'(ENTRIES - 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(ENTRIES - 1);

    pcam_op_e   op;
    pcam_src_e  src;
    pcam_step_e step;

    assign op   = pcam_op_e'(acc_op);
    assign src  = pcam_src_e'(acc_src);
    assign step = pcam_step_e'(ar_step);

    logic [WIDTH-1:0]   cam_keep;
    logic [ENTRIES-1:0] hits, empties;
    logic [WIDTH-1:0]   rd_word;
    logic               hit_found, nf_found;
    logic [AW-1:0]      hit_idx, nf_idx;
    logic [AW-1:0]      tgt;
    logic               tgt_ok;
    logic               match_flag_q;
    logic [AW-1:0]      match_addr_q, ar_q;
    logic [WIDTH-1:0]   rd_q;
    logic               direct_ok, access_go;

    assign direct_ok = ({1'b0, acc_addr} <= TOP_IDX);

    always_comb begin
        unique case (src)
            SRC_DIRECT: begin tgt = acc_addr;     tgt_ok = direct_ok;    end
            SRC_AREG:   begin tgt = ar_q;         tgt_ok = 1'b1;         end
            SRC_FREE:   begin tgt = nf_idx;       tgt_ok = nf_found;     end
            default:    begin tgt = match_addr_q; tgt_ok = match_flag_q; end
        endcase
    end

    assign access_go = tgt_ok && (op == OP_READ || op == OP_WRITE);

    pcam_part_decode #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_part (
        .part_code (part_code),
        .cam_keep  (cam_keep)
    );

    pcam_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_array (
        .clk       (clk),
        .rst       (rst),
        .we        (tgt_ok && op == OP_WRITE),
        .set_skip  (tgt_ok && op == OP_SKIP),
        .set_free  (tgt_ok && op == OP_FREE),
        .idx       (tgt),
        .wdata     (acc_data),
        .wmask     (acc_mask),
        .comparand (comparand),
        .cmp_mask  (cmp_mask),
        .cam_keep  (cam_keep),
        .hits      (hits),
        .empties   (empties),
        .rd_word   (rd_word)
    );

    pcam_prio #(.N(ENTRIES)) u_hit_prio (
        .req   (hits),
        .found (hit_found),
        .idx   (hit_idx)
    );

    pcam_prio #(.N(ENTRIES)) u_free_prio (
        .req   (empties),
        .found (nf_found),
        .idx   (nf_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            match_flag_q <= 1'b0;
            match_addr_q <= '0;
            ar_q         <= '0;
            rd_q         <= '0;
        end else begin
            if (cmp_strobe) begin
                match_flag_q <= hit_found;
                match_addr_q <= hit_idx;
            end
            if (op == OP_READ && tgt_ok) rd_q <= rd_word;
            if (op == OP_LOAD_AR) begin
                if (direct_ok) ar_q <= acc_addr;
            end else if (access_go) begin
                unique case (step)
                    STEP_INC: ar_q <= (ar_q == LAST_IDX) ? '0 : ar_q + 1'b1;
                    STEP_DEC: ar_q <= (ar_q == '0) ? LAST_IDX : ar_q - 1'b1;
                    default:  ar_q <= ar_q;
                endcase
            end
        end
    end

    assign match_flag = match_flag_q;
    assign match_addr = match_addr_q;
    assign full_flag  = !nf_found;
    assign next_free  = nf_found ? nf_idx : '0;
    assign addr_reg   = ar_q;
    assign rd_data    = rd_q;

    // R5
    match_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmp_strobe |=> ($stable(match_flag_q) && $stable(match_addr_q)));

    // R5
    hit_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        hit_found |-> (hits[hit_idx] &&
                       ((hits & ((ENTRIES'(1) << hit_idx) - 1'b1)) == '0)));

    // R7
    full_empty_chk: assert property (@(posedge clk) disable iff (rst)
        full_flag |-> (empties == '0));

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (access_go && op != OP_LOAD_AR && step == STEP_INC) |=>
        (ar_q == (($past(ar_q) == LAST_IDX) ? '0 : $past(ar_q) + 1'b1)));

endmodule

// File: tb/pcam_top_tb.sv
module pcam_top_tb;
    localparam int ENTRIES = 6;
    localparam int WIDTH   = 64;
    localparam int SEG_W   = 16;
    localparam int AW      = 3;

    typedef struct packed {
        logic [2:0]       part;
        logic [WIDTH-1:0] cmp;
        logic [WIDTH-1:0] msk;
        logic             flag;
        logic [AW-1:0]    addr;
    } vec_t;

    localparam logic [63:0] E0 = 64'h1111_2222_3333_4444;
    localparam logic [63:0] E1 = 64'h1111_2222_3333_5555;
    localparam logic [63:0] E2 = 64'hAAAA_2222_3333_4444;
    localparam logic [63:0] E3 = 64'h9999_8888_7777_6666;

    localparam vec_t VECS [13] = '{
        '{3'd0, E0, 64'h0, 1'b1, 3'd0},
        '{3'd0, E1, 64'h0, 1'b1, 3'd1},
        '{3'd0, 64'h1111_2222_3333_6666, 64'h0, 1'b0, 3'd0},
        '{3'd1, 64'h1111_2222_3333_6666, 64'h0, 1'b1, 3'd0},
        '{3'd4, 64'h1111_2222_3333_6666, 64'h0, 1'b0, 3'd0},
        '{3'd5, 64'h0000_2222_3333_5555, 64'h0, 1'b1, 3'd1},
        '{3'd7, 64'h0000_0000_0000_6666, 64'h0, 1'b1, 3'd3},
        '{3'd3, 64'hAAAA_0000_0000_0000, 64'h0, 1'b1, 3'd2},
        '{3'd2, 64'h1111_2222_0000_0000, 64'h0, 1'b1, 3'd0},
        '{3'd6, 64'h0000_0000_7777_6666, 64'h0, 1'b1, 3'd3},
        '{3'd0, 64'h1111_2222_3333_0000, 64'h0000_0000_0000_FFFF, 1'b1, 3'd0},
        '{3'd0, 64'h0000_2222_3333_4444, 64'hFFFF_0000_0000_0000, 1'b1, 3'd0},
        '{3'd0, E2, 64'h0, 1'b1, 3'd2}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       part_code = '0;
    logic             cmp_strobe = 1'b0;
    logic [WIDTH-1:0] comparand = '0;
    logic [WIDTH-1:0] cmp_mask = '0;
    logic [2:0]       acc_op = '0;
    logic [1:0]       acc_src = '0;
    logic [AW-1:0]    acc_addr = '0;
    logic [WIDTH-1:0] acc_data = '0;
    logic [WIDTH-1:0] acc_mask = '0;
    logic [1:0]       ar_step = '0;
    logic             match_flag, full_flag;
    logic [AW-1:0]    match_addr, next_free, addr_reg;
    logic [WIDTH-1:0] rd_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pcam_top #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .SEG_W(SEG_W)) u_dut (
        .clk(clk), .rst(rst), .part_code(part_code), .cmp_strobe(cmp_strobe),
        .comparand(comparand), .cmp_mask(cmp_mask), .acc_op(acc_op),
        .acc_src(acc_src), .acc_addr(acc_addr), .acc_data(acc_data),
        .acc_mask(acc_mask), .ar_step(ar_step), .match_flag(match_flag),
        .match_addr(match_addr), .full_flag(full_flag), .next_free(next_free),
        .addr_reg(addr_reg), .rd_data(rd_data)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] op, input logic [1:0] src,
                          input logic [AW-1:0] addr, input logic [63:0] data,
                          input logic [63:0] msk, input logic [1:0] step);
        acc_op = op; acc_src = src; acc_addr = addr;
        acc_data = data; acc_mask = msk; ar_step = step;
        tick();
        acc_op = 3'd0; ar_step = 2'd0;
    endtask

    task automatic compare(input logic [2:0] part, input logic [63:0] cmp, input logic [63:0] msk);
        part_code = part; comparand = cmp; cmp_mask = msk; cmp_strobe = 1'b1;
        tick();
        cmp_strobe = 1'b0;
    endtask

    task automatic read_at(input logic [AW-1:0] a);
        access(3'd1, 2'd0, a, 64'h0, 64'h0, 2'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        check("R1 full_flag", 64'(full_flag), 64'd0);
        check("R1 next_free", 64'(next_free), 64'd0);
        check("R1 addr_reg", 64'(addr_reg), 64'd0);
        check("R1 match_flag", 64'(match_flag), 64'd0);
        // R4: empty entries never match, even with all-zero data
        compare(3'd0, 64'h0, 64'h0);
        check("R4 empty no match", 64'(match_flag), 64'd0);

        access(3'd2, 2'd0, 3'd0, E0, 64'h0, 2'd0);
        access(3'd2, 2'd0, 3'd1, E1, 64'h0, 2'd0);
        access(3'd2, 2'd0, 3'd2, E2, 64'h0, 2'd0);
        access(3'd2, 2'd0, 3'd3, E3, 64'h0, 2'd0);
        check("R7 next_free after 4 writes", 64'(next_free), 64'd4);

        // R2 R3 R5 vector table
        for (int i = 0; i < 13; i++) begin
            compare(VECS[i].part, VECS[i].cmp, VECS[i].msk);
            check($sformatf("R2/R3 vec%0d flag", i), 64'(match_flag), 64'(VECS[i].flag));
            if (VECS[i].flag)
                check($sformatf("R5 vec%0d addr", i), 64'(match_addr), 64'(VECS[i].addr));
        end

        // R5 hold without strobe
        comparand = E0;
        tick();
        check("R5 hold addr", 64'(match_addr), 64'd2);
        check("R5 hold flag", 64'(match_flag), 64'd1);

        // R4 skipped entry excluded
        access(3'd3, 2'd0, 3'd0, 64'h0, 64'h0, 2'd0);
        compare(3'd0, 64'h0000_2222_3333_4444, 64'hFFFF_0000_0000_0000);
        check("R4 skip excluded", 64'(match_addr), 64'd2);

        // R10 free op, R4 freed entry excluded
        access(3'd4, 2'd0, 3'd2, 64'h0, 64'h0, 2'd0);
        compare(3'd0, E2, 64'h0);
        check("R4 freed no match", 64'(match_flag), 64'd0);
        check("R10 free sets next_free", 64'(next_free), 64'd2);

        // R6 masked write, R10 read
        access(3'd2, 2'd0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 2'd0);
        read_at(3'd1);
        check("R6 masked write", rd_data, 64'hFFFF_FFFF_3333_5555);

        // R7 R8 fill through next-free source
        access(3'd2, 2'd2, 3'd0, 64'hC2, 64'h0, 2'd0);
        check("R7 next_free 4", 64'(next_free), 64'd4);
        access(3'd2, 2'd2, 3'd0, 64'hC4, 64'h0, 2'd0);
        access(3'd2, 2'd2, 3'd0, 64'hC5, 64'h0, 2'd0);
        check("R7 full set", 64'(full_flag), 64'd1);
        check("R7 next_free when full", 64'(next_free), 64'd0);
        access(3'd2, 2'd2, 3'd0, 64'hDEAD, 64'h0, 2'd0);
        read_at(3'd0);
        check("R8 dropped write when full", rd_data, E0);
        read_at(3'd2);
        check("R8 next-free write target", rd_data, 64'hC2);

        // R6 write clears skip
        access(3'd2, 2'd0, 3'd0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0);
        compare(3'd0, E0, 64'h0);
        check("R6 write clears skip", 64'(match_flag), 64'd1);

        // R9 address register
        access(3'd5, 2'd0, 3'd4, 64'h0, 64'h0, 2'd0);
        check("R9 load", 64'(addr_reg), 64'd4);
        access(3'd1, 2'd1, 3'd0, 64'h0, 64'h0, 2'd1);
        check("R9 read via areg", rd_data, 64'hC4);
        check("R9 inc", 64'(addr_reg), 64'd5);
        access(3'd1, 2'd1, 3'd0, 64'h0, 64'h0, 2'd1);
        check("R9 inc data", rd_data, 64'hC5);
        check("R9 inc wrap", 64'(addr_reg), 64'd0);
        access(3'd1, 2'd1, 3'd0, 64'h0, 64'h0, 2'd2);
        check("R9 dec wrap", 64'(addr_reg), 64'd5);
        access(3'd1, 2'd1, 3'd0, 64'h0, 64'h0, 2'd0);
        check("R9 hold", 64'(addr_reg), 64'd5);

        // R8 match source
        compare(3'd0, E3, 64'h0);
        check("R8 match setup", 64'(match_addr), 64'd3);
        access(3'd2, 2'd3, 3'd0, 64'h0, 64'hFFFF_FFFF_FFFF_0000, 2'd0);
        read_at(3'd3);
        check("R8 match-source write", rd_data, 64'h9999_8888_7777_0000);
        compare(3'd0, 64'h1234, 64'h0);
        access(3'd2, 2'd3, 3'd0, 64'h0, 64'h0, 2'd0);
        read_at(3'd3);
        check("R8 dropped without match", rd_data, 64'h9999_8888_7777_0000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule